// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a dual-port memory and watches the left and right access ports. When both ports are enabled on the same address in the same cycle, it picks one owner for that location. It pulls an active-low busy line low toward the other port and suppresses that port's write strobe. The port that started its access on the address first wins. When both arrive in the same cycle, the left port wins. The chosen owner is kept for as long as the contention lasts.

A mode strap lets several devices be stacked for wider words. With the strap high, the block is a master: it arbitrates and drives the busy lines with its own decision. With the strap low, it is a slave: it makes no decision of its own and takes externally supplied busy lines as the result. In slave mode a write is only let through once the external busy has been inactive for a full cycle, so that no write begins while the master's result may still be moving. All setup windows are expressed in clock cycles.

Top module: `dp_contention_arb`

## Requirements
- R1: In master mode, contention exists only when both enables are high and the two addresses are equal. Without contention, both busy outputs are high (inactive).
- R2: A port is "settled" when it was enabled in the previous cycle with the same address it presents now. When contention starts and exactly one port is settled, that port wins. Busy goes low to the other port in the same cycle that contention appears.
- R3: When contention starts and neither port, or both ports, are settled, the left port wins, so the right busy output goes low.
- R4: In master mode there is exactly one low busy output during contention, and the two busy outputs are never low together.
- R5: While contention continues from one cycle to the next, the owner does not change, even if the arrival conditions change. In the first cycle without contention, both busy outputs return high.
- R6: In master mode, a port's write strobe output equals enable AND write request AND that port's busy being high. The external busy inputs have no effect in master mode.
- R7: In slave mode, each busy output follows its external busy input in the same cycle, and no arbitration takes place. During contention with both external inputs high, both writes pass.
- R8: In slave mode, a port's write strobe output is high only when its enable and write request are high and its external busy input is high both in this cycle and in the previous cycle.
- R9: While reset is applied, with both enables low, both busy outputs are high and both write strobe outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| master_en | input | 1 | 1 = master (arbitrates), 0 = slave (uses external busy) |
| l_en | input | 1 | Left port access enable, active high |
| l_addr | input | AW | Left port address |
| l_wr_req | input | 1 | Left port write request |
| r_en | input | 1 | Right port access enable, active high |
| r_addr | input | AW | Right port address |
| r_wr_req | input | 1 | Right port write request |
| ext_l_busy_n | input | 1 | External busy toward the left port (slave mode), active low |
| ext_r_busy_n | input | 1 | External busy toward the right port (slave mode), active low |
| l_busy_n | output | 1 | Busy toward the left port, active low |
| r_busy_n | output | 1 | Busy toward the right port, active low |
| l_wr_ok | output | 1 | Qualified left write strobe |
| r_wr_ok | output | 1 | Qualified right write strobe |

## Verification
The assertions assume that every input is driven to a known level throughout reset, and that the mode strap has been steady for at least one cycle before its checks are relied on. The first-come and settling properties look back one cycle, so they only apply from the second cycle after the internal reset has been released. The stimulus holds all inputs at defined values from time zero. It draws addresses from a four-entry subset so that matches happen often, and changes the mode only in separate phases, each of which lasts many cycles.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  localparam int NPORT = 2;
  localparam int PL    = 0;
  localparam int PR    = 1;
endpackage

// File: rtl/dpa_port_track.sv
module dpa_port_track #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic          settled
);
  logic          en_q, en_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          trk_ce;

  // capture only while the port is or was active
  assign trk_ce = en | en_q;

  always_comb begin
    en_d   = en_q;
    addr_d = addr_q;
    if (trk_ce) begin
      en_d   = en;
      addr_d = addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en_d;
      addr_q <= addr_d;
    end
  end

  assign settled = en & en_q & (addr == addr_q);
endmodule

// File: rtl/dpa_arb_core.sv
module dpa_arb_core
  import dpa_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   contend,
  input  logic   l_settled,
  input  logic   r_settled,
  output owner_e owner
);
  owner_e owner_q, owner_d, fresh;

  // fresh pick: earlier arrival wins, ties go to the left
  always_comb begin
    if (r_settled && !l_settled) fresh = OWN_RIGHT;
    else                         fresh = OWN_LEFT;
  end

  always_comb begin
    if (!contend)                owner_d = OWN_NONE;
    else if (owner_q != OWN_NONE) owner_d = owner_q;
    else                         owner_d = fresh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= OWN_NONE;
    else        owner_q <= owner_d;
  end

  assign owner = owner_d;
endmodule

// File: rtl/dpa_wr_gate.sv
module dpa_wr_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic master_en,
  input  logic en,
  input  logic wr_req,
  input  logic arb_busy,
  input  logic ext_busy_n,
  output logic busy_n,
  output logic wr_ok
);
  logic ext_q, ext_d;
  logic settle_ok;

  always_comb ext_d = ext_busy_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= 1'b1;
    else        ext_q <= ext_d;
  end

  assign settle_ok = ext_busy_n & ext_q;

  always_comb begin
    if (master_en) begin
      busy_n = ~arb_busy;
      wr_ok  = en & wr_req & ~arb_busy;
    end else begin
      busy_n = ext_busy_n;
      wr_ok  = en & wr_req & settle_ok;
    end
  end
endmodule

// File: rtl/dp_contention_arb.sv
module dp_contention_arb
  import dpa_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master_en,
  input  logic          l_en,
  input  logic [AW-1:0] l_addr,
  input  logic          l_wr_req,
  input  logic          r_en,
  input  logic [AW-1:0] r_addr,
  input  logic          r_wr_req,
  input  logic          ext_l_busy_n,
  input  logic          ext_r_busy_n,
  output logic          l_busy_n,
  output logic          r_busy_n,
  output logic          l_wr_ok,
  output logic          r_wr_ok
);
  logic          rst_meta, rst_sync_n;
  logic          en_v      [NPORT];
  logic [AW-1:0] addr_v    [NPORT];
  logic          req_v     [NPORT];
  logic          ext_v     [NPORT];
  logic          settled_v [NPORT];
  logic          arb_busy_v[NPORT];
  logic          busy_v    [NPORT];
  logic          wr_v      [NPORT];
  logic          contend;
  owner_e        owner;

  // reset: asserted at once, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign en_v[PL]   = l_en;     assign en_v[PR]   = r_en;
  assign addr_v[PL] = l_addr;   assign addr_v[PR] = r_addr;
  assign req_v[PL]  = l_wr_req; assign req_v[PR]  = r_wr_req;
  assign ext_v[PL]  = ext_l_busy_n;
  assign ext_v[PR]  = ext_r_busy_n;

  assign contend = l_en & r_en & (l_addr == r_addr);

  dpa_arb_core u_core (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .contend   (contend),
    .l_settled (settled_v[PL]),
    .r_settled (settled_v[PR]),
    .owner     (owner)
  );

  assign arb_busy_v[PL] = (owner == OWN_RIGHT);
  assign arb_busy_v[PR] = (owner == OWN_LEFT);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpa_port_track #(.AW(AW)) u_trk (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .en      (en_v[p]),
      .addr    (addr_v[p]),
      .settled (settled_v[p])
    );
    dpa_wr_gate u_gate (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .master_en  (master_en),
      .en         (en_v[p]),
      .wr_req     (req_v[p]),
      .arb_busy   (arb_busy_v[p]),
      .ext_busy_n (ext_v[p]),
      .busy_n     (busy_v[p]),
      .wr_ok      (wr_v[p])
    );
  end

  assign l_busy_n = busy_v[PL];
  assign r_busy_n = busy_v[PR];
  assign l_wr_ok  = wr_v[PL];
  assign r_wr_ok  = wr_v[PR];
endmodule

// File: rtl/dpa_checker.sv
module dpa_checker #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_ni,
  input logic          master_en,
  input logic          l_en,
  input logic [AW-1:0] l_addr,
  input logic          l_wr_req,
  input logic          r_en,
  input logic [AW-1:0] r_addr,
  input logic          r_wr_req,
  input logic          ext_l_busy_n,
  input logic          ext_r_busy_n,
  input logic          l_busy_n,
  input logic          r_busy_n,
  input logic          l_wr_ok,
  input logic          r_wr_ok
);
  logic cont;
  assign cont = l_en && r_en && (l_addr == r_addr);

  p_idle_free_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    master_en && !cont |-> l_busy_n && r_busy_n);

  p_first_left_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    master_en && $past(rst_ni) && cont && !$past(cont) &&
    $past(l_en) && (l_addr == $past(l_addr)) &&
    !($past(r_en) && (r_addr == $past(r_addr))) |-> !r_busy_n);

  p_one_loser_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    master_en && cont |-> $countones({l_busy_n, r_busy_n}) == 1);

  p_never_both_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    master_en |-> (l_busy_n || r_busy_n));

  p_hold_owner_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    master_en && $past(master_en) && $past(rst_ni) && cont && $past(cont)
    |-> $stable(l_busy_n) && $stable(r_busy_n));

  p_block_write_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (!l_busy_n |-> !l_wr_ok) and (!r_busy_n |-> !r_wr_ok));

  p_slave_mirror_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    !master_en |-> (l_busy_n == ext_l_busy_n) && (r_busy_n == ext_r_busy_n));

  p_slave_settle_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    !master_en && $past(rst_ni) && !$past(ext_l_busy_n) |-> !l_wr_ok);
endmodule

bind dp_contention_arb dpa_checker #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_ni       (rst_sync_n),
  .master_en    (master_en),
  .l_en         (l_en),
  .l_addr       (l_addr),
  .l_wr_req     (l_wr_req),
  .r_en         (r_en),
  .r_addr       (r_addr),
  .r_wr_req     (r_wr_req),
  .ext_l_busy_n (ext_l_busy_n),
  .ext_r_busy_n (ext_r_busy_n),
  .l_busy_n     (l_busy_n),
  .r_busy_n     (r_busy_n),
  .l_wr_ok      (l_wr_ok),
  .r_wr_ok      (r_wr_ok)
);

// File: tb/sim_dp_contention_arb.sv
`timescale 1ns/1ps
module sim_dp_contention_arb;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_en = 1'b1;
  logic l_en = 1'b0, r_en = 1'b0, l_wr_req = 1'b0, r_wr_req = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic ext_l_busy_n = 1'b1, ext_r_busy_n = 1'b1;
  logic l_busy_n, r_busy_n, l_wr_ok, r_wr_ok;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench model state (prior cycle)
  logic          p_len = 1'b0, p_ren = 1'b0;
  logic [AW-1:0] p_laddr = '0, p_raddr = '0;
  logic          p_lext = 1'b1, p_rext = 1'b1;
  int            m_own = 0;  // 0 none, 1 left, 2 right
  int            cur_own = 0;

  always #2 clk = ~clk;

  dp_contention_arb #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .master_en(master_en),
    .l_en(l_en), .l_addr(l_addr), .l_wr_req(l_wr_req),
    .r_en(r_en), .r_addr(r_addr), .r_wr_req(r_wr_req),
    .ext_l_busy_n(ext_l_busy_n), .ext_r_busy_n(ext_r_busy_n),
    .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
    .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok)
  );

  function automatic int next_owner();
    logic cont, ls, rs;
    cont = l_en && r_en && (l_addr == r_addr);
    ls = l_en && p_len && (l_addr == p_laddr);
    rs = r_en && p_ren && (r_addr == p_raddr);
    if (!cont) return 0;
    if (m_own != 0) return m_own;
    if (rs && !ls) return 2;
    return 1;
  endfunction

  function automatic string busy_tag();
    logic cont, ls, rs;
    cont = l_en && r_en && (l_addr == r_addr);
    ls = l_en && p_len && (l_addr == p_laddr);
    rs = r_en && p_ren && (r_addr == p_raddr);
    if (!master_en) return "R7";
    if (!cont) return "R1";
    if (m_own != 0) return "R5";
    if (ls != rs) return "R2";
    return "R3";
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    logic eb_l, eb_r, ew_l, ew_r;
    string bt;
    cur_own = next_owner();
    bt = busy_tag();
    if (master_en) begin
      eb_l = (cur_own != 2);
      eb_r = (cur_own != 1);
      ew_l = l_en && l_wr_req && eb_l;
      ew_r = r_en && r_wr_req && eb_r;
    end else begin
      eb_l = ext_l_busy_n;
      eb_r = ext_r_busy_n;
      ew_l = l_en && l_wr_req && ext_l_busy_n && p_lext;
      ew_r = r_en && r_wr_req && ext_r_busy_n && p_rext;
    end
    chk(bt, "l_busy_n", l_busy_n, eb_l);
    chk(bt, "r_busy_n", r_busy_n, eb_r);
    chk(master_en ? "R6" : "R8", "l_wr_ok", l_wr_ok, ew_l);
    chk(master_en ? "R6" : "R8", "r_wr_ok", r_wr_ok, ew_r);
    if (master_en && cur_own != 0)  // R4: exactly one busy low
      chk("R4", "one busy low", (l_busy_n ^ r_busy_n), 1'b1);
  endtask

  task automatic update_model();
    m_own = master_en ? cur_own : next_owner();
    if (l_en || p_len) begin p_len = l_en; p_laddr = l_addr; end
    if (r_en || p_ren) begin p_ren = r_en; p_raddr = r_addr; end
    p_lext = ext_l_busy_n;
    p_rext = ext_r_busy_n;
  endtask

  task automatic step(input logic me, input logic le, input int la, input logic lw,
                      input logic re, input int ra, input logic rw,
                      input logic xl, input logic xr);
    @(negedge clk);
    master_en = me; l_en = le; l_addr = AW'(la); l_wr_req = lw;
    r_en = re; r_addr = AW'(ra); r_wr_req = rw;
    ext_l_busy_n = xl; ext_r_busy_n = xr;
    #1;
    check_all();
    @(posedge clk);
    update_model();
  endtask

  task automatic rand_step(input logic me);
    step(me, 1'($urandom_range(0, 3) != 0), int'($urandom_range(0, 3)), 1'($urandom),
             1'($urandom_range(0, 3) != 0), int'($urandom_range(0, 3)), 1'($urandom),
             1'($urandom_range(0, 2) != 0), 1'($urandom_range(0, 2) != 0));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    chk("R9", "l_busy_n in reset", l_busy_n, 1'b1);
    chk("R9", "r_busy_n in reset", r_busy_n, 1'b1);
    chk("R9", "l_wr_ok in reset", l_wr_ok, 1'b0);
    chk("R9", "r_wr_ok in reset", r_wr_ok, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R2: left settled first, right joins -> right busy
    step(1, 1, 5, 1, 0, 0, 0, 1, 1);
    step(1, 1, 5, 1, 1, 5, 1, 0, 0);
    chk("R2", "right loses to earlier left", r_busy_n, 1'b0);
    // R5: hold while contention lasts, then release
    step(1, 1, 5, 1, 1, 5, 1, 1, 1);
    step(1, 0, 5, 0, 1, 5, 1, 1, 1);
    chk("R5", "release after winner drops", r_busy_n, 1'b1);
    // R2: right first this time
    step(1, 0, 0, 0, 1, 9, 1, 1, 1);
    step(1, 1, 9, 1, 1, 9, 1, 1, 1);
    chk("R2", "left loses to earlier right", l_busy_n, 1'b0);
    // R5: owner kept when right changes address together with left
    step(1, 1, 7, 1, 1, 7, 1, 1, 1);
    chk("R5", "owner kept across joint move", l_busy_n, 1'b0);
    step(1, 0, 0, 0, 0, 0, 0, 1, 1);
    // R3: simultaneous arrival -> left wins
    step(1, 1, 3, 1, 1, 3, 1, 1, 1);
    chk("R3", "tie goes left", r_busy_n, 1'b0);
    step(1, 1, 3, 1, 1, 4, 1, 1, 1);
    chk("R1", "diverged addresses free", r_busy_n, 1'b1);
    // R7/R8: slave mode
    step(0, 1, 2, 1, 1, 2, 1, 1, 1);
    chk("R7", "slave both writes pass", r_wr_ok & l_wr_ok, 1'b1);
    step(0, 1, 2, 1, 1, 2, 1, 0, 1);
    step(0, 1, 2, 1, 1, 2, 1, 1, 1);
    chk("R8", "left write held one settle cycle", l_wr_ok, 1'b0);
    step(0, 1, 2, 1, 1, 2, 1, 1, 1);
    chk("R8", "left write after settle", l_wr_ok, 1'b1);

    for (int ph = 0; ph < 8; ph++) begin
      for (int i = 0; i < 1500; i++) rand_step((ph % 4) != 3);
    end
    finish_run();
  end
endmodule